// File: doc/BRIEF.md
# Fractional-Drop Pixel Clock Divider

This block turns a fast source clock into a pixel-rate enable strobe for a display panel. One 32-bit configuration word sets the strobe rate. Its low half is an integer divisor N, and the source clock is divided by N. A 12-bit fraction F then removes a share of the divided ticks, so the mean output rate is (source / N) * (1 - F/4096). The top bit of the word is a source-select flag. The block registers it and passes it to the clock multiplexer outside. A free-running divided clock with a duty cycle of about one half is also provided for consumers that need a real clock edge instead of an enable.

The integer divisor never falls below 2. Reprogramming is glitch-safe. A new word is sampled only on the last source cycle of the period in progress, so the period being counted always completes at its old length. A phase accumulator decides which ticks to drop. On every integer period end it adds F, and a tick is suppressed each time the sum carries past 4096.

Top module: `pixclk_divider`

## Requirements
- R1: While reset is asserted, pixEn, divClk and srcSelPll are all low.
- R2: With a divisor N of at least 2 in bits 15:0 and a fraction of 0, pixEn is a single-cycle pulse repeating exactly every N source cycles.
- R3: A programmed divisor of 0 or 1 behaves exactly like a divisor of 2.
- R4: Bit 31 of cfgWord appears on srcSelPll after the current period ends, and it does not change the pulse spacing.
- R5: The fraction F sits in bits 27:16. In any run of divided ticks, the accumulator adds F per tick and drops one tick per carry past 4096. Any 4096/gcd(F,4096) consecutive ticks therefore lose exactly F/gcd(F,4096) pulses, and F = 0 drops none.
- R6: divClk is high for floor(N/2) source cycles of every N-cycle period.
- R7: A new divisor, fraction or select value is taken only at the end of the current period. A period already under way completes at its old length.
- R8: Bits 30:28 of cfgWord are ignored. Setting them changes neither the pulse spacing nor srcSelPll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWord | input | 32 | Divisor [15:0], fraction [27:16], source select [31] |
| pixEn | output | 1 | One-cycle pixel clock enable |
| divClk | output | 1 | Integer-divided clock, high floor(N/2) cycles per period |
| srcSelPll | output | 1 | Registered source-select flag |

## Verification
The bench looks first at divisors 0 and 1. A design without clamping would hang or pulse every cycle there, and it would miss the expected 2-cycle gap. The bench also changes the divisor in the middle of a long period. A design that loads the new value at once would cut that period short and produce a runt gap instead of the full old length. For the fraction, pulses are counted over whole drop patterns at several values of F. An accumulator that drops on the wrong carry, or that drops when F is zero, would give the wrong pulse total. The divided clock's high time is measured on both an odd and an even divisor, which catches rounding of N/2 in the wrong direction.

// File: rtl/pixclk_div_pkg.sv
package pixclk_div_pkg;
  // Strobes from the period counter to the fraction datapath.
  typedef struct packed {
    logic periodEnd;  // last source cycle of the current integer period
  } ctrlStrobe_t;
endpackage

// File: rtl/pixclk_div_ctrl.sv
module pixclk_div_ctrl
  import pixclk_div_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int MIN_DIV = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divReq,
  output ctrlStrobe_t      strobe,
  output logic             divClk
);
  logic [DIV_W-1:0] cnt, curDiv, clampDiv, cntNext, divNext;
  logic atEnd;

  // Divisors below the floor are raised to it.
  always_comb begin
    clampDiv = (divReq < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : divReq;
    atEnd    = (cnt == curDiv - 1'b1);
    cntNext  = atEnd ? '0 : cnt + 1'b1;
    divNext  = atEnd ? clampDiv : curDiv;
    strobe.periodEnd = atEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      curDiv <= DIV_W'(MIN_DIV);
      divClk <= 1'b0;
    end else begin
      cnt    <= cntNext;
      curDiv <= divNext;
      divClk <= (cntNext < (divNext >> 1));
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) cnt < curDiv); // R2
  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rstN) curDiv >= DIV_W'(MIN_DIV)); // R3
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strobe.periodEnd |=> $stable(curDiv)); // R7
endmodule

// File: rtl/pixclk_frac_dp.sv
module pixclk_frac_dp
  import pixclk_div_pkg::*;
#(
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [FRAC_W-1:0] fracReq,
  input  logic              selReq,
  output logic              pixEn,
  output logic              srcSel
);
  logic [FRAC_W-1:0] curFrac, phase;
  logic [FRAC_W:0]   phaseSum;
  logic              dropTick;

  // A carry out of the phase accumulator removes this tick.
  always_comb begin
    phaseSum = {1'b0, phase} + {1'b0, curFrac};
    dropTick = phaseSum[FRAC_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      curFrac <= '0;
      srcSel  <= 1'b0;
      pixEn   <= 1'b0;
    end else if (strobe.periodEnd) begin
      phase   <= phaseSum[FRAC_W-1:0];
      pixEn   <= !dropTick;
      curFrac <= fracReq;
      srcSel  <= selReq;
    end else begin
      pixEn   <= 1'b0;
    end
  end

  AST_PIX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN) pixEn |=> !pixEn); // R2
  AST_PIX_ON_TICK: assert property (@(posedge clk) disable iff (!rstN) pixEn |-> $past(strobe.periodEnd)); // R5
  AST_NO_DROP_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN) (strobe.periodEnd && curFrac == '0) |=> pixEn); // R5
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN) !strobe.periodEnd |=> ($stable(curFrac) && $stable(srcSel))); // R7
endmodule

// File: rtl/pixclk_divider.sv
module pixclk_divider
  import pixclk_div_pkg::*;
#(
  parameter int CFG_W    = 32,
  parameter int DIV_W    = 16,
  parameter int FRAC_W   = 12,
  parameter int FRAC_LSB = 16,
  parameter int SEL_BIT  = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             pixEn,
  output logic             divClk,
  output logic             srcSelPll
);
  localparam int FRAC_MSB = FRAC_LSB + FRAC_W - 1;
  localparam int MIN_DIV  = 2;

  ctrlStrobe_t strobe;

  pixclk_div_ctrl #(.DIV_W(DIV_W), .MIN_DIV(MIN_DIV)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .divReq (cfgWord[DIV_W-1:0]),
    .strobe (strobe),
    .divClk (divClk)
  );

  pixclk_frac_dp #(.FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .fracReq (cfgWord[FRAC_MSB:FRAC_LSB]),
    .selReq  (cfgWord[SEL_BIT]),
    .pixEn   (pixEn),
    .srcSel  (srcSelPll)
  );
endmodule

// File: tb/test_pixclk_divider.sv
`timescale 1ns/1ps
module test_pixclk_divider;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic pixEn, divClk, srcSelPll;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pixclk_divider i_pixclk_divider (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord),
    .pixEn(pixEn), .divClk(divClk), .srcSelPll(srcSelPll)
  );

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Count negedges until pixEn is seen high.
  task automatic waitPulse(output int gap);
    gap = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      gap++;
      if (pixEn) return;
    end
  endtask

  task automatic setupRun(input logic [31:0] cfg);
    int g;
    cfgWord = cfg;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitPulse(g);
    waitPulse(g);
  endtask

  task automatic tReset();
    cfgWord = 32'h8000_0005;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R1", "pixEn in reset", int'(pixEn), 0);
    checkEq("R1", "divClk in reset", int'(divClk), 0);
    checkEq("R1", "srcSelPll in reset", int'(srcSelPll), 0);
  endtask

  task automatic tSpacing(input int n);
    int g;
    setupRun(32'(n));
    for (int k = 0; k < 3; k++) begin
      waitPulse(g);
      checkEq("R2", $sformatf("gap N=%0d", n), g, n);
    end
    @(negedge clk);
    checkEq("R2", "pulse width one cycle", int'(pixEn), 0);
  endtask

  task automatic tClamp(input int n);
    int g;
    setupRun(32'(n));
    waitPulse(g);
    checkEq("R3", $sformatf("gap for divisor %0d", n), g, 2);
  endtask

  task automatic tSource();
    int g;
    setupRun(32'h8000_0006);
    checkEq("R4", "srcSelPll set", int'(srcSelPll), 1);
    waitPulse(g);
    checkEq("R4", "gap with select bit", g, 6);
    cfgWord = 32'h0000_0006;
    @(negedge clk);
    checkEq("R7", "select held mid-period", int'(srcSelPll), 1);
    waitPulse(g);
    checkEq("R4", "select cleared at period end", int'(srcSelPll), 0);
    checkEq("R7", "gap across select change", g + 1, 6);
  endtask

  task automatic tFraction(input int n, input int f, input int ticks, input int expPulses);
    int g, cnt;
    setupRun((32'(f) << 16) | 32'(n));
    waitPulse(g);
    cnt = 0;
    for (int i = 0; i < n * ticks; i++) begin
      @(negedge clk);
      if (pixEn) cnt++;
    end
    checkEq("R5", $sformatf("pulses N=%0d F=%0d", n, f), cnt, expPulses);
  endtask

  task automatic tDivClk(input int n);
    int g, hi;
    setupRun(32'(n));
    hi = 0;
    for (int i = 0; i < n * 4; i++) begin
      @(negedge clk);
      if (divClk) hi++;
    end
    checkEq("R6", $sformatf("divClk high cycles N=%0d", n), hi, 4 * (n / 2));
  endtask

  task automatic tReload();
    int g;
    setupRun(32'd8);
    waitPulse(g);
    repeat (2) @(negedge clk);
    cfgWord = 32'd3;
    waitPulse(g);
    checkEq("R7", "period in progress keeps old length", g + 2, 8);
    waitPulse(g);
    checkEq("R7", "new divisor after boundary", g, 3);
  endtask

  task automatic tIgnored();
    int g;
    setupRun(32'h7000_0005);
    waitPulse(g);
    checkEq("R8", "gap with bits 30:28 set", g, 5);
    checkEq("R8", "srcSelPll unaffected", int'(srcSelPll), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tReset();
    tSpacing(5);
    tSpacing(2);
    tSpacing(17);
    tClamp(0);
    tClamp(1);
    tSource();
    tFraction(3, 1024, 16, 12);
    tFraction(2, 2048, 32, 16);
    tFraction(4, 0, 20, 20);
    tFraction(2, 3072, 16, 4);
    tDivClk(7);
    tDivClk(4);
    tReload();
    tIgnored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule